// File: doc/BRIEF.md
# Two-Group Round-Robin Bus Arbiter

This block decides which of six masters owns a shared parallel bus. Five of the masters are external and one is the bridge's own internal master. A 16-bit control word places each master in either a high-priority group or a low-priority group. Masters in the high group take turns in a ring. The whole low group takes a single seat in that ring, placed after master 5. When that seat comes up, one low-group master is chosen by a second, independent round-robin.

Grants are registered and one-hot. They can move only in a cycle where the bus-idle input is high. When nobody is requesting, the bus is parked. The parking target is either the master that last held the grant or the internal master, as a control bit selects.

Top module: `dual_tier_arbiter`

## Requirements
- R1: After reset, the grant is `6'b100000`, which is the internal master at index 5. Both ring pointers start at seat 0, so with all six masters requesting in the high group, the first grant goes to master 0.
- R2: Exactly one bit of `gnt` is set in every cycle after reset.
- R3: In a cycle where `bus_idle` is low, `gnt` holds its value on the next clock, whatever the requests or the control word do.
- R4: `arb_ctrl[i]` for i in 0..5 puts master i in the high group when it is 1 and in the low group when it is 0. `arb_ctrl[8]` selects parking: 0 parks on the last agent, 1 parks on the internal master. Bits 7:6 and 15:9 have no effect on the grant.
- R5: In the high ring, the seat after the last high winner has first priority. A high-group master that wins is therefore not granted again ahead of any other waiting high-group master.
- R6: The low group fills exactly one seat, seat 6, in the high ring. After that seat wins, high priority restarts at seat 0.
- R7: The low-group pointer moves to the seat after the chosen low master, and it moves only when the low seat wins. A high win leaves the low order unchanged.
- R8: With no request, `bus_idle` high and `arb_ctrl[8]=0`, the grant stays on the current holder.
- R9: With no request, `bus_idle` high and `arb_ctrl[8]=1`, the grant moves to the internal master (`gnt[5]`).
- R10: All six masters may share one group. All high gives a plain six-way rotation. All low gives a six-way rotation through the low seat.
- R11: When any request is present and `bus_idle` is high, the next grant goes to a master that is requesting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 6 | Request per master; index 5 is the internal master |
| bus_idle | input | 1 | High when ownership of the bus may change |
| arb_ctrl | input | 16 | Group bits [5:0] and parking bit [8] |
| gnt | output | 6 | One-hot registered grant |

## Verification
The bench drives the arbiter through the corner cases below, each of which catches a specific fault.
- A high master that requests without a break must not be granted twice in a row while others wait. A ring pointer that fails to advance past the winner shows up as that master being granted again.
- A mixed group split interleaves low-group grants into the high ring. A design that gives each low master its own seat, or that steps the low pointer on high wins, produces the wrong grant order.
- Requests that change while the bus is busy must leave `gnt` unchanged. A design that re-arbitrates in that cycle fails this check.
- Idle periods with no request are run under both parking modes. A swapped parking bit lands the grant on the wrong master.
- A control word with stray upper bits set must behave exactly like its clean counterpart. This exposes decoding that uses bits outside [5:0] and [8].

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned ARB_NREQ     = 6;
  localparam int unsigned ARB_CTRL_W   = 16;
  localparam int unsigned ARB_INT_IDX  = 5;
  localparam int unsigned ARB_PARK_BIT = 8;
endpackage

// File: rtl/arb_cfg_decode.sv
module arb_cfg_decode #(
  parameter int unsigned N_REQ    = arb_pkg::ARB_NREQ,
  parameter int unsigned CTRL_W   = arb_pkg::ARB_CTRL_W,
  parameter int unsigned PARK_BIT = arb_pkg::ARB_PARK_BIT
) (
  input  logic [CTRL_W-1:0] ctrl,
  output logic [N_REQ-1:0]  grp_hi,
  output logic              park_bridge
);
  // R4: only group bits and the parking bit are used
  logic unused_ctrl_bits;

  assign grp_hi           = ctrl[N_REQ-1:0];
  assign park_bridge      = ctrl[PARK_BIT];
  assign unused_ctrl_bits = ^ctrl;
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int unsigned W  = 6,
  parameter int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  input  logic [IW-1:0] ptr,
  output logic          valid,
  output logic [IW-1:0] idx
);
  always_comb begin : pick
    int s;
    valid = 1'b0;
    idx   = '0;
    // walk from farthest offset down so the nearest set bit is kept
    for (int k = W - 1; k >= 0; k--) begin
      s = int'(ptr) + k;
      if (s >= int'(W)) s = s - int'(W);
      if (vec[IW'(s)]) begin
        valid = 1'b1;
        idx   = IW'(s);
      end
    end
  end

  // R11: a chosen seat is always one that is asking
  always_comb begin
    if (valid) a_r11_pick_requesting: assert (vec[idx]);
  end
endmodule

// File: rtl/dual_tier_arbiter.sv
module dual_tier_arbiter #(
  parameter int unsigned N_REQ    = arb_pkg::ARB_NREQ,
  parameter int unsigned CTRL_W   = arb_pkg::ARB_CTRL_W,
  parameter int unsigned INT_IDX  = arb_pkg::ARB_INT_IDX,
  parameter int unsigned PARK_BIT = arb_pkg::ARB_PARK_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_REQ-1:0]  req,
  input  logic              bus_idle,
  input  logic [CTRL_W-1:0] arb_ctrl,
  output logic [N_REQ-1:0]  gnt
);
  localparam int unsigned SLOTS = N_REQ + 1;
  localparam int unsigned HPW   = $clog2(SLOTS);
  localparam int unsigned LPW   = $clog2(N_REQ);

  logic [N_REQ-1:0] grp_hi;
  logic             park_bridge;
  logic [N_REQ-1:0] hi_req, lo_req;
  logic [SLOTS-1:0] ring_vec;
  logic             hi_valid, lo_valid;
  logic [HPW-1:0]   hi_idx;
  logic [LPW-1:0]   lo_idx;

  logic [N_REQ-1:0] gnt_q, gnt_n;
  logic [HPW-1:0]   hp_q, hp_n;
  logic [LPW-1:0]   lp_q, lp_n;
  logic             upd_en;

  arb_cfg_decode #(.N_REQ(N_REQ), .CTRL_W(CTRL_W), .PARK_BIT(PARK_BIT)) u_cfg (
    .ctrl        (arb_ctrl),
    .grp_hi      (grp_hi),
    .park_bridge (park_bridge)
  );

  assign hi_req   = req & grp_hi;
  assign lo_req   = req & ~grp_hi;
  assign ring_vec = {|lo_req, hi_req};   // R6: low group is the last seat

  arb_rr_pick #(.W(SLOTS), .IW(HPW)) u_hi (
    .vec (ring_vec), .ptr (hp_q), .valid (hi_valid), .idx (hi_idx)
  );

  arb_rr_pick #(.W(N_REQ), .IW(LPW)) u_lo (
    .vec (lo_req), .ptr (lp_q), .valid (lo_valid), .idx (lo_idx)
  );

  assign upd_en = bus_idle;

  // next-state
  always_comb begin
    gnt_n = gnt_q;
    hp_n  = hp_q;
    lp_n  = lp_q;
    if (hi_valid) begin
      if (hi_idx == HPW'(N_REQ)) begin
        gnt_n = N_REQ'(1) << lo_idx;
        lp_n  = (lo_idx == LPW'(N_REQ - 1)) ? '0 : lo_idx + LPW'(1);
        hp_n  = '0;
      end else begin
        gnt_n = N_REQ'(1) << hi_idx;
        hp_n  = hi_idx + HPW'(1);
      end
    end else if (park_bridge) begin
      gnt_n = N_REQ'(1) << INT_IDX;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q <= N_REQ'(1) << INT_IDX;
      hp_q  <= '0;
      lp_q  <= '0;
    end else if (upd_en) begin
      gnt_q <= gnt_n;
      hp_q  <= hp_n;
      lp_q  <= lp_n;
    end
  end

  assign gnt = gnt_q;

  // R2: exactly one grant
  a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gnt) == 1);

  // R3: grant frozen while bus busy
  a_r3_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_idle |=> $stable(gnt));

  // R11: grant goes to a requester
  a_r11_grant_requester: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_idle && |req) |=> |(gnt & $past(req)));

  // R9: park on internal master
  a_r9_park_bridge: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_idle && req == '0 && arb_ctrl[PARK_BIT]) |=> gnt[INT_IDX]);

  // R8: park on last agent
  a_r8_park_last: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_idle && req == '0 && !arb_ctrl[PARK_BIT]) |=> $stable(gnt));

  // R7: low pointer only moves when a low master is granted
  a_r7_lo_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_idle && hi_valid && hi_idx == HPW'(N_REQ)) |=> $stable(lp_q));
endmodule

// File: tb/sim_dual_tier_arbiter.sv
module sim_dual_tier_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  req = '0;
  logic        bus_idle = 1'b0;
  logic [15:0] arb_ctrl = '0;
  logic [5:0]  gnt;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [5:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  // reference model state
  logic [5:0] m_gnt;
  int m_hp, m_lp;

  always #2 clk = ~clk;   // 250 MHz

  dual_tier_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .bus_idle(bus_idle),
    .arb_ctrl(arb_ctrl), .gnt(gnt)
  );

  task automatic model_step(input logic [5:0] r, input logic idle, input logic [15:0] c);
    logic [5:0] hi, lo;
    bit found;
    if (!idle) return;
    hi = r & c[5:0];
    lo = r & ~c[5:0];
    if (r == '0) begin
      if (c[8]) m_gnt = 6'b100000;
      return;
    end
    found = 0;
    for (int k = 0; k < 7; k++) begin
      int s;
      s = (m_hp + k) % 7;
      if (!found) begin
        if (s < 6 && hi[s]) begin
          found = 1; m_gnt = 6'd1 << s; m_hp = (s + 1) % 7;
        end else if (s == 6 && lo != '0) begin
          found = 1; m_hp = 0;
          for (int j = 0; j < 6; j++) begin
            int t;
            t = (m_lp + j) % 6;
            if (found && lo[t] && m_hp == 0 && m_gnt != 6'd1 << t && j >= 0) begin
              m_gnt = 6'd1 << t; m_lp = (t + 1) % 6; m_hp = 7;
            end
          end
          m_hp = 0;
        end
      end
    end
  endtask

  task automatic step(input logic [5:0] r, input logic idle, input logic [15:0] c, input string tag);
    item_t it;
    @(negedge clk);
    req = r; bus_idle = idle; arb_ctrl = c;
    model_step(r, idle, c);
    it.exp = m_gnt; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (gnt !== it.exp) begin
        failures++;
        $display("FAIL %s: gnt=%b expected=%b", it.tag, gnt, it.exp);
      end
      checks++;
      if ($countones(gnt) != 1) begin
        failures++;
        $display("FAIL R2: gnt=%b expected exactly one bit", gnt);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: done=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_gnt = 6'b100000; m_hp = 0; m_lp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (gnt !== 6'b100000) begin
      failures++;
      $display("FAIL R1: gnt=%b expected=%b", gnt, 6'b100000);
    end
    // R1 R5 R10: all high, plain rotation starting at master 0
    for (int i = 0; i < 7; i++) step(6'b111111, 1'b1, 16'h003F, "R5/R10 all-high rotation");
    // R3: busy bus freezes grant under changing requests
    step(6'b000100, 1'b0, 16'h003F, "R3 hold busy");
    step(6'b010000, 1'b0, 16'h0000, "R3 hold busy");
    step(6'b000000, 1'b0, 16'h0100, "R3 hold busy");
    // R6 R7: masters 0..2 high, 3..5 low
    for (int i = 0; i < 10; i++) step(6'b111111, 1'b1, 16'h0007, "R6/R7 mixed groups");
    // R7: high-only wins leave low order alone
    step(6'b000011, 1'b1, 16'h0007, "R7 high wins only");
    step(6'b000011, 1'b1, 16'h0007, "R7 high wins only");
    step(6'b111000, 1'b1, 16'h0007, "R7 low order kept");
    step(6'b111000, 1'b1, 16'h0007, "R7 low order kept");
    // R8: park on last
    step(6'b000000, 1'b1, 16'h0007, "R8 park last");
    step(6'b000000, 1'b1, 16'h0007, "R8 park last");
    // R9: park on bridge
    step(6'b000010, 1'b1, 16'h0107, "R11 single requester");
    step(6'b000000, 1'b1, 16'h0107, "R9 park bridge");
    step(6'b000000, 1'b1, 16'h0107, "R9 park bridge");
    // R4: stray bits ignored, all low group
    for (int i = 0; i < 7; i++) step(6'b111111, 1'b1, 16'hFEC0, "R4/R10 stray bits all-low");
    step(6'b000000, 1'b1, 16'hFEC0, "R4 stray bits park last");
    // R11: sparse requests
    step(6'b001000, 1'b1, 16'h0015, "R11 sparse");
    step(6'b100001, 1'b1, 16'h0015, "R11 sparse");
    step(6'b100001, 1'b1, 16'h0015, "R11 sparse");
    step(6'b000000, 1'b0, 16'h0015, "R3 hold busy");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule